// File: doc/BRIEF.md
# Triggered Windowed Ring-Buffer Recorder

This block stores a stream of 32-bit samples in memory. The memory region is divided into a configurable number of equal windows that sit back to back. While a window is open, it acts as a ring buffer, so it always holds the most recent pre-trigger history. When a trigger is accepted, the block stores the trigger sample and a programmable number of further samples, then closes the window. At close it records the window's last written byte address and a timestamp, and it moves on to the next window, wrapping modulo the window count.

The recording mode decides which triggers count. Continuous mode honours every trigger. Trigger-mask mode honours a trigger only while the stream is armed. Single mode stores nothing until the stream is armed. Manual mode treats the arm strobe itself as the trigger. The arm flag clears once the window that an armed trigger closed has been recorded. In linear mode the window closes as soon as it is full. In stop mode the block waits, dropping samples, until the host releases the next window. In overwrite mode it reuses windows in order.

The controller has four states:
- IDLE: the stream is disabled.
- PRE: a window is open and waiting for a trigger.
- POST: the post-trigger count is running.
- HOLD: stop mode is waiting for a window to be released.

Its transitions are:
- IDLE→PRE: enable, with the current window free or overwrite set.
- IDLE→HOLD: enable, with the current window unreleased and stop mode selected.
- PRE→POST: an accepted trigger with a nonzero post count.
- PRE→PRE and POST→PRE: a close, with the next window usable.
- PRE→HOLD and POST→HOLD: a close, with the next window unreleased in stop mode.
- HOLD→PRE: the current window is released.
- any state→IDLE: enable cleared.

Top module: `trig_win_recorder`

## Requirements
- R1: Window n starts at byte address base + n*size*4, where size is counted in samples. The first sample stored after a window opens goes to the window start, and each later sample goes to the next 4-byte slot.
- R2: Each stored sample produces exactly one write on the memory port, in the clock cycle after the sample is accepted, carrying the sample unchanged as a little-endian 32-bit word (bits 7:0 at the lowest byte address).
- R3: In ring mode (`cfg_ring`=1) the slot after the last slot of a window is that window's first slot.
- R4: After an accepted trigger, the block stores the trigger sample plus exactly `cfg_post` further samples and then closes the window. `win_last` of that window holds the byte address of the final sample.
- R5: On close, `cur_win` advances by one modulo `cfg_win_cnt`, and that window's `win_ts` holds the `ts_in` value at the closing sample.
- R6: A window's sample count rises by one per stored sample and saturates at `cfg_win_size`.
- R7: Mode encodings are 0 continuous, 1 single, 2 trigger-mask and 3 manual. In trigger-mask mode a trigger closes a window only while armed, and one armed window clears the arm.
- R8: In single mode, samples are not stored while the stream is unarmed.
- R9: In manual mode `smp_trig` has no effect, and the first valid sample after an arm strobe is taken as the trigger.
- R10: A trigger that arrives during the post-trigger count is ignored.
- R11: In linear mode (`cfg_ring`=0) a window closes when its last slot is written.
- R12: With `cfg_overwrite`=0, a window already closed and not yet released through `win_ack` blocks recording: samples are dropped until it is released. With `cfg_overwrite`=1 windows are reused in order.
- R13: While `cfg_enable` is low, no write occurs and `cur_win` does not change.
- R14: A synchronous reset clears `cur_win`, the write strobe, the counts and the timestamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample valid |
| smp_trig | input | 1 | Trigger flag for this sample |
| smp_data | input | 32 | Sample value |
| ts_in | input | TS_W | Free-running time value |
| cfg_enable | input | 1 | Stream enable |
| cfg_mode | input | 2 | Recording mode |
| cfg_arm | input | 1 | One-cycle arm strobe |
| cfg_ring | input | 1 | 1 = ring buffer, 0 = linear |
| cfg_overwrite | input | 1 | 1 = overwrite, 0 = stop when full |
| cfg_base | input | ADDR_W | Byte base address |
| cfg_win_size | input | CNT_W | Window size in samples |
| cfg_win_cnt | input | WIN_W+1 | Number of windows (1..MAX_WIN) |
| cfg_post | input | CNT_W | Post-trigger sample count |
| win_ack | input | 1 | Release strobe for a window |
| win_ack_idx | input | WIN_W | Window being released |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory byte address |
| wr_data | output | 32 | Memory write word |
| cur_win | output | WIN_W | Current window index |
| win_cnt | output | MAX_WIN*CNT_W | Per-window sample counts |
| win_last | output | MAX_WIN*ADDR_W | Per-window last written address |
| win_ts | output | MAX_WIN*TS_W | Per-window close timestamp |

## Verification
The following properties are checked on every cycle:
- every write lands word-aligned inside the configured region;
- `cur_win` only steps by one or wraps to zero, and stays below the window count;
- counts never exceed the window size;
- a disabled stream neither writes nor changes window.

The bench scenarios cover the rest, which a single-cycle property cannot see: the exact trigger-to-close distance, wrap position, mode gating of triggers, arm clearing, stop-mode blocking and release, and timestamp capture. Random pre-trigger lengths and post counts are compared against the expected last address and count.

// File: rtl/twr_pkg.sv
package twr_pkg;
    localparam int SMP_W = 32;

    typedef enum logic [1:0] {
        MODE_CONT   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_MASK   = 2'd2,
        MODE_MANUAL = 2'd3
    } rec_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_HOLD
    } rec_state_e;
endpackage

// File: rtl/twr_ctrl.sv
module twr_ctrl
    import twr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             smp_trig,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_arm,
    input  logic             cfg_ring,
    input  logic             cfg_overwrite,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic             at_end,
    input  logic             cur_busy,
    input  logic             nxt_busy,
    output logic             store,
    output logic             close,
    output logic             restart
);
    rec_state_e       state_q, state_d;
    rec_mode_e        mode;
    logic [CNT_W-1:0] post_rem_q;
    logic             armed_q, armed_hit_q;
    logic             active, gate, trig_cond, trig_ok, hit_now, post_done, start;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // decoded outputs
    always_comb begin
        mode   = rec_mode_e'(cfg_mode);
        active = cfg_enable && (state_q == ST_PRE || state_q == ST_POST);
        gate   = (mode == MODE_SINGLE) ? armed_q : 1'b1;
        store  = active && smp_vld && gate;
        unique case (mode)
            MODE_CONT:   trig_cond = smp_trig;
            MODE_SINGLE: trig_cond = smp_trig && armed_q;
            MODE_MASK:   trig_cond = smp_trig && armed_q;
            MODE_MANUAL: trig_cond = armed_q;
        endcase
        trig_ok   = store && (state_q == ST_PRE) && trig_cond;
        hit_now   = trig_ok && (mode != MODE_CONT);
        post_done = (state_q == ST_POST && post_rem_q == '0) ||
                    (trig_ok && cfg_post == '0);
        close     = store && (post_done || (!cfg_ring && at_end));
        start     = cfg_enable &&
                    ((state_q == ST_IDLE && !(cur_busy && !cfg_overwrite)) ||
                     (state_q == ST_HOLD && !cur_busy));
        restart   = close || start;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_enable)
                    state_d = (cur_busy && !cfg_overwrite) ? ST_HOLD : ST_PRE;
            end
            ST_PRE, ST_POST: begin
                if (!cfg_enable)  state_d = ST_IDLE;
                else if (close)   state_d = (nxt_busy && !cfg_overwrite) ? ST_HOLD : ST_PRE;
                else if (trig_ok) state_d = ST_POST;
            end
            ST_HOLD: begin
                if (!cfg_enable)    state_d = ST_IDLE;
                else if (!cur_busy) state_d = ST_PRE;
            end
        endcase
    end

    // post-trigger counter and arm tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            post_rem_q  <= '0;
            armed_q     <= 1'b0;
            armed_hit_q <= 1'b0;
        end else begin
            if (trig_ok)
                post_rem_q <= cfg_post - 1'b1;
            else if (store && state_q == ST_POST && post_rem_q != '0)
                post_rem_q <= post_rem_q - 1'b1;

            if (cfg_arm)
                armed_q <= 1'b1;
            else if (close && (armed_hit_q || hit_now))
                armed_q <= 1'b0;

            if (restart)      armed_hit_q <= 1'b0;
            else if (hit_now) armed_hit_q <= 1'b1;
        end
    end
endmodule

// File: rtl/twr_addr.sv
module twr_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_win_size,
    input  logic [WIN_W-1:0]  cur_win,
    input  logic              store,
    input  logic              restart,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              at_end
);
    logic [CNT_W-1:0] slot_q;

    assign at_end   = (slot_q == cfg_win_size - 1'b1);
    assign cur_addr = cfg_base +
        ((ADDR_W'(cur_win) * ADDR_W'(cfg_win_size) + ADDR_W'(slot_q)) << 2);

    always_ff @(posedge clk) begin
        if (rst || restart) slot_q <= '0;
        else if (store)     slot_q <= at_end ? '0 : slot_q + 1'b1;
    end
endmodule

// File: rtl/twr_winstat.sv
module twr_winstat #(
    parameter int MAX_WIN = 4,
    parameter int WIN_W   = 2,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int TS_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      store,
    input  logic                      close,
    input  logic                      restart,
    input  logic [ADDR_W-1:0]         cur_addr,
    input  logic [TS_W-1:0]           ts_in,
    input  logic [CNT_W-1:0]          cfg_win_size,
    input  logic [WIN_W:0]            cfg_win_cnt,
    input  logic                      win_ack,
    input  logic [WIN_W-1:0]          win_ack_idx,
    output logic [WIN_W-1:0]          cur_win,
    output logic                      cur_busy,
    output logic                      nxt_busy,
    output logic [MAX_WIN*CNT_W-1:0]  cnt_flat,
    output logic [MAX_WIN*ADDR_W-1:0] last_flat,
    output logic [MAX_WIN*TS_W-1:0]   ts_flat
);
    logic [WIN_W-1:0] cur_q, nxt;
    logic [WIN_W:0]   cur_plus;
    logic             fresh_q;
    logic [MAX_WIN-1:0] used_w;

    assign cur_plus = {1'b0, cur_q} + 1'b1;
    assign nxt      = (cur_plus >= cfg_win_cnt) ? '0 : cur_plus[WIN_W-1:0];
    assign cur_win  = cur_q;
    assign cur_busy = used_w[cur_q];
    assign nxt_busy = used_w[nxt] || (nxt == cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            fresh_q <= 1'b1;
        end else begin
            if (close) cur_q <= nxt;
            if (restart)    fresh_q <= 1'b1;
            else if (store) fresh_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
        logic [CNT_W-1:0]  cnt_r;
        logic [ADDR_W-1:0] last_r;
        logic [TS_W-1:0]   ts_r;
        logic              used_r;
        logic              sel;

        assign sel = (cur_q == WIN_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_r  <= '0;
                last_r <= '0;
                ts_r   <= '0;
                used_r <= 1'b0;
            end else begin
                if (store && sel)
                    cnt_r <= fresh_q ? CNT_W'(1) :
                             (cnt_r >= cfg_win_size) ? cfg_win_size : cnt_r + 1'b1;
                if (close && sel) begin
                    last_r <= cur_addr;
                    ts_r   <= ts_in;
                    used_r <= 1'b1;
                end else if (win_ack && win_ack_idx == WIN_W'(g)) begin
                    used_r <= 1'b0;
                end
            end
        end

        assign used_w[g]                     = used_r;
        assign cnt_flat[g*CNT_W +: CNT_W]    = cnt_r;
        assign last_flat[g*ADDR_W +: ADDR_W] = last_r;
        assign ts_flat[g*TS_W +: TS_W]       = ts_r;
    end
endmodule

// File: rtl/trig_win_recorder.sv
module trig_win_recorder
    import twr_pkg::*;
#(
    parameter int MAX_WIN = 4,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int TS_W    = 32,
    localparam int WIN_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_vld,
    input  logic                      smp_trig,
    input  logic [SMP_W-1:0]          smp_data,
    input  logic [TS_W-1:0]           ts_in,
    input  logic                      cfg_enable,
    input  logic [1:0]                cfg_mode,
    input  logic                      cfg_arm,
    input  logic                      cfg_ring,
    input  logic                      cfg_overwrite,
    input  logic [ADDR_W-1:0]         cfg_base,
    input  logic [CNT_W-1:0]          cfg_win_size,
    input  logic [WIN_W:0]            cfg_win_cnt,
    input  logic [CNT_W-1:0]          cfg_post,
    input  logic                      win_ack,
    input  logic [WIN_W-1:0]          win_ack_idx,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [SMP_W-1:0]          wr_data,
    output logic [WIN_W-1:0]          cur_win,
    output logic [MAX_WIN*CNT_W-1:0]  win_cnt,
    output logic [MAX_WIN*ADDR_W-1:0] win_last,
    output logic [MAX_WIN*TS_W-1:0]   win_ts
);
    logic              store, close, restart, at_end, cur_busy, nxt_busy;
    logic [ADDR_W-1:0] cur_addr;

    twr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_trig(smp_trig),
        .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_arm(cfg_arm),
        .cfg_ring(cfg_ring), .cfg_overwrite(cfg_overwrite), .cfg_post(cfg_post),
        .at_end(at_end), .cur_busy(cur_busy), .nxt_busy(nxt_busy),
        .store(store), .close(close), .restart(restart)
    );

    twr_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_addr (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_win_size(cfg_win_size),
        .cur_win(cur_win), .store(store), .restart(restart),
        .cur_addr(cur_addr), .at_end(at_end)
    );

    twr_winstat #(.MAX_WIN(MAX_WIN), .WIN_W(WIN_W), .CNT_W(CNT_W),
                  .ADDR_W(ADDR_W), .TS_W(TS_W)) u_stat (
        .clk(clk), .rst(rst), .store(store), .close(close), .restart(restart),
        .cur_addr(cur_addr), .ts_in(ts_in), .cfg_win_size(cfg_win_size),
        .cfg_win_cnt(cfg_win_cnt), .win_ack(win_ack), .win_ack_idx(win_ack_idx),
        .cur_win(cur_win), .cur_busy(cur_busy), .nxt_busy(nxt_busy),
        .cnt_flat(win_cnt), .last_flat(win_last), .ts_flat(win_ts)
    );

    // registered memory write port
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= store;
            wr_addr <= cur_addr;
            wr_data <= smp_data;
        end
    end
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
    parameter int MAX_WIN = 4,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 32,
    localparam int WIN_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_enable,
    input logic [ADDR_W-1:0]        cfg_base,
    input logic [CNT_W-1:0]         cfg_win_size,
    input logic [WIN_W:0]           cfg_win_cnt,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [WIN_W-1:0]         cur_win,
    input logic [MAX_WIN*CNT_W-1:0] win_cnt
);
    a_r1_write_in_region: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[1:0] == 2'b00 &&
                   (wr_addr - cfg_base) < ((ADDR_W'(cfg_win_cnt) * ADDR_W'(cfg_win_size)) << 2)));

    a_r5_win_step: assert property (@(posedge clk) disable iff (rst)
        (cur_win != $past(cur_win)) |-> (cur_win == WIN_W'($past(cur_win) + 1'b1) || cur_win == '0));

    a_r5_win_below_cnt: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cur_win} < cfg_win_cnt);

    a_r13_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !wr_en);

    a_r13_win_frozen: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> $stable(cur_win));

    for (genvar g = 0; g < MAX_WIN; g++) begin : g_cnt
        a_r6_cnt_sat: assert property (@(posedge clk) disable iff (rst)
            win_cnt[g*CNT_W +: CNT_W] <= cfg_win_size);
    end
endmodule

bind trig_win_recorder twr_checker #(.MAX_WIN(MAX_WIN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_twr_checker (.*);

// File: tb/trig_win_recorder_bench.sv
`timescale 1ns/1ps
module trig_win_recorder_bench;
    localparam int MAX_WIN = 4;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int TS_W    = 32;
    localparam int WIN_W   = 2;
    localparam int BASE    = 32'h1000;
    localparam int SIZE    = 8;
    localparam int NWIN    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 0, smp_trig = 0;
    logic [31:0] smp_data = '0;
    logic [TS_W-1:0] ts_ctr = 32'd1000;
    logic cfg_enable = 0, cfg_arm = 0, cfg_ring = 1, cfg_overwrite = 1;
    logic [1:0] cfg_mode = 2'd0;
    logic [ADDR_W-1:0] cfg_base = BASE;
    logic [CNT_W-1:0] cfg_win_size = SIZE;
    logic [WIN_W:0] cfg_win_cnt = NWIN;
    logic [CNT_W-1:0] cfg_post = 16'd2;
    logic win_ack = 0;
    logic [WIN_W-1:0] win_ack_idx = '0;
    logic wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0] wr_data;
    logic [WIN_W-1:0] cur_win;
    logic [MAX_WIN*CNT_W-1:0] win_cnt;
    logic [MAX_WIN*ADDR_W-1:0] win_last;
    logic [MAX_WIN*TS_W-1:0] win_ts;

    trig_win_recorder u_trig_win_recorder (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_trig(smp_trig),
        .smp_data(smp_data), .ts_in(ts_ctr), .cfg_enable(cfg_enable),
        .cfg_mode(cfg_mode), .cfg_arm(cfg_arm), .cfg_ring(cfg_ring),
        .cfg_overwrite(cfg_overwrite), .cfg_base(cfg_base),
        .cfg_win_size(cfg_win_size), .cfg_win_cnt(cfg_win_cnt),
        .cfg_post(cfg_post), .win_ack(win_ack), .win_ack_idx(win_ack_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_win(cur_win), .win_cnt(win_cnt), .win_last(win_last), .win_ts(win_ts)
    );

    always #10 clk = ~clk;
    always @(posedge clk) ts_ctr <= ts_ctr + 1;

    int errs = 0, checks = 0;
    bit done = 0;
    logic got_en;
    logic [31:0] got_addr, got_data, sent, last_ts;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint exp_addr(input int w, input int slot);
        return BASE + (w * SIZE + slot) * 4;
    endfunction
    function automatic longint exp_cnt(input int total);
        return (total > SIZE) ? SIZE : total;
    endfunction
    function automatic int nxt_win(input int w);
        return (w + 1) % NWIN;
    endfunction
    function automatic longint cnt_of(input int w);
        return win_cnt[w*CNT_W +: CNT_W];
    endfunction
    function automatic longint last_of(input int w);
        return win_last[w*ADDR_W +: ADDR_W];
    endfunction
    function automatic longint ts_of(input int w);
        return win_ts[w*TS_W +: TS_W];
    endfunction

    task automatic push(input bit t);
        @(negedge clk);
        sent = $urandom;
        smp_vld = 1; smp_trig = t; smp_data = sent; last_ts = ts_ctr;
        @(posedge clk); #1;
        smp_vld = 0; smp_trig = 0;
        got_en = wr_en; got_addr = wr_addr; got_data = wr_data;
    endtask

    task automatic arm();
        @(negedge clk); cfg_arm = 1;
        @(posedge clk); #1; cfg_arm = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int w;
        void'($urandom(32'd2718));
        idle(3);
        @(negedge clk); rst = 0;
        #1;
        chk("R14", "wr_en after reset", wr_en, 0);
        chk("R14", "cur_win after reset", cur_win, 0);
        chk("R14", "count after reset", cnt_of(0), 0);
        chk("R14", "ts after reset", ts_of(0), 0);

        // continuous, ring, overwrite
        @(negedge clk); cfg_enable = 1;
        idle(1);
        for (int i = 0; i < 10; i++) begin
            push(0);
            chk("R2", "write strobe", got_en, 1);
            chk("R2", "write data", got_data, sent);
            chk(i < 8 ? "R1" : "R3", "slot address", got_addr, exp_addr(0, i % 8));
        end
        chk("R6", "saturated count", cnt_of(0), 8);
        push(1);
        chk("R3", "trigger slot", got_addr, exp_addr(0, 2));
        push(0);
        push(0);
        chk("R5", "window advance", cur_win, 1);
        chk("R4", "last address", last_of(0), exp_addr(0, 4));
        chk("R5", "timestamp", ts_of(0), last_ts);
        chk("R6", "count after close", cnt_of(0), 8);

        push(1); push(1);
        chk("R10", "no close mid post", cur_win, 1);
        push(0);
        chk("R10", "window advance", cur_win, 2);
        chk("R10", "last address", last_of(1), exp_addr(1, 2));
        chk("R6", "partial count", cnt_of(1), 3);
        push(1); push(0); push(0);
        chk("R5", "modulo wrap", cur_win, 0);
        push(0);
        chk("R12", "overwrite reuse", got_addr, exp_addr(0, 0));

        // trigger-mask
        @(negedge clk); cfg_mode = 2'd2;
        push(1); push(0); push(0);
        chk("R7", "unarmed trigger", cur_win, 0);
        arm();
        push(1); push(0); push(0);
        chk("R7", "armed close", cur_win, 1);
        chk("R7", "last address", last_of(0), exp_addr(0, 6));
        push(1); push(0); push(0);
        chk("R7", "arm cleared", cur_win, 1);

        // single
        @(negedge clk); cfg_mode = 2'd1;
        push(0);
        chk("R8", "unarmed drop", got_en, 0);
        arm();
        push(1); push(0); push(0);
        chk("R8", "armed close", cur_win, 2);
        chk("R8", "last address", last_of(1), exp_addr(1, 5));
        push(0);
        chk("R8", "disarmed drop", got_en, 0);

        // manual
        @(negedge clk); cfg_mode = 2'd3;
        push(1);
        chk("R9", "stored", got_en, 1);
        chk("R9", "input trigger ignored", cur_win, 2);
        arm();
        push(0); push(0); push(0);
        chk("R9", "arm as trigger", cur_win, 0);
        chk("R9", "last address", last_of(2), exp_addr(2, 3));

        // random lengths, continuous
        @(negedge clk); cfg_mode = 2'd0;
        for (int r = 0; r < 8; r++) begin
            int pre, post, total;
            w = cur_win;
            pre = $urandom_range(19, 0);
            post = $urandom_range(5, 0);
            @(negedge clk); cfg_post = CNT_W'(post);
            for (int k = 0; k < pre; k++) push(0);
            push(1);
            for (int k = 0; k < post; k++) push(0);
            total = pre + 1 + post;
            chk("R5", "random advance", cur_win, nxt_win(w));
            chk("R4", "random last", last_of(w), exp_addr(w, (total - 1) % SIZE));
            chk("R6", "random count", cnt_of(w), exp_cnt(total));
        end
        @(negedge clk); cfg_post = 16'd2;

        // disabled
        @(negedge clk); cfg_enable = 0;
        w = cur_win;
        for (int k = 0; k < 4; k++) begin
            push(1);
            chk("R13", "no write when disabled", got_en, 0);
        end
        chk("R13", "window frozen", cur_win, w);

        // linear
        @(negedge clk); cfg_ring = 0; cfg_enable = 1;
        idle(1);
        for (int k = 0; k < 7; k++) push(0);
        chk("R11", "not yet full", cur_win, w);
        push(0);
        chk("R11", "close when full", cur_win, nxt_win(w));
        chk("R11", "last address", last_of(w), exp_addr(w, 7));

        // stop mode
        @(negedge clk); cfg_enable = 0;
        @(negedge clk); cfg_overwrite = 0; cfg_ring = 1; cfg_enable = 1;
        idle(1);
        w = cur_win;
        push(0);
        chk("R12", "blocked window drops", got_en, 0);
        @(negedge clk); win_ack = 1; win_ack_idx = WIN_W'(w);
        @(posedge clk); #1; win_ack = 0;
        idle(1);
        push(0);
        chk("R12", "released window writes", got_addr, exp_addr(w, 0));
        push(1); push(0); push(0);
        chk("R12", "advance", cur_win, nxt_win(w));
        push(0);
        chk("R12", "next busy drops", got_en, 0);

        finish_run();
    end
endmodule